// File: doc/BRIEF.md
# Serial-command bus master bridge

This block is a serial peripheral slave that turns each command frame it receives into a single-byte read or write on a Wishbone bus. An external host selects the slave, shifts in a fixed 32-bit frame, and keeps clocking while the bridge waits for the bus. Each frame holds a direction flag, a 23-bit byte address and a data byte. The serial clock, select and data-in lines are oversampled with the system clock, so the block has a single clock domain. The serial clock must run no faster than one quarter of the system clock.

Bus latency is not fixed, so the reply has no fixed position in the frame. The data-out line stays low while the bus cycle is outstanding. When the data is ready, the bridge sends a single 1 as a marker and then the 8-bit result. The host scans the incoming bit stream for the first 1 and takes the next eight bits as the result. Bus arbitration and the bus slaves are outside this block.

Top module: `spi_wb_bridge`

## Requirements
- R1: After reset, `wb_cyc_o` and `wb_stb_o` are low and `spi_miso` is 0.
- R2: The first frame bit (bit 31, sent first) selects the direction: 1 gives a write (`wb_we_o`=1) and 0 gives a read (`wb_we_o`=0).
- R3: Frame bits 30..8 are the address, MSB first, and appear unchanged on `wb_adr_o[22:0]`. All bits are sampled on rising edges of `spi_sck`, which idles high (clock polarity 1, phase 1).
- R4: Frame bits 7..0 are the write data and appear on `wb_dat_o` during a write. On a read these bits do not change the result and do not modify the target.
- R5: Exactly one bus cycle starts per complete frame, and only after the 32nd bit. `wb_cyc_o` and `wb_stb_o` stay high with a stable address and direction until `wb_ack_i`, and both are low in the cycle after the acknowledge.
- R6: After the 32nd bit, `spi_miso` reads 0 at every rising clock edge until the bus has acknowledged. It then reads a single 1, followed by the 8 result bits MSB first, one per rising `spi_sck` edge. A read returns the bus data.
- R7: A write returns the result byte 0x00.
- R8: Raising `spi_ss_n` before the 32nd bit abandons the frame: no bus cycle starts, `spi_miso` returns to 0, and the next frame is decoded from its first bit.
- R9: `spi_mosi` bits clocked in after the 32nd bit are ignored. They start no further bus cycle and do not alter the reply.
- R10: Once the marker and the 8 result bits have been sent, `spi_miso` reads 0 for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_sck | input | 1 | Serial clock, idle high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial reply to host |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 23 | Bus byte address |
| wb_dat_o | output | 8 | Bus write data |
| wb_dat_i | input | 8 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The hardest case to reach is the race between bus latency and the serial bit slots. The marker must never appear in a slot the host samples before the acknowledge, whether the acknowledge comes in the first system cycle or dozens of cycles later. The bench therefore runs a bus slave model whose acknowledge delay is set per frame, from zero up to forty cycles. It timestamps every host sample, and for each frame it checks that the first 1 on `spi_miso` was sampled after the acknowledge cycle. Aborted frames and data-in activity during the reply are mixed into the same run, so that a stray second bus cycle or a shifted reply is also caught.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;

   // Bus master state.
   typedef enum logic {
      BUS_IDLE = 1'b0,
      BUS_WAIT = 1'b1
   } bus_state_e;

   // Header = direction flag followed by the address.
   function automatic int hdr_bits(input int adr_w);
      return adr_w + 1;
   endfunction

   function automatic int frame_bits(input int adr_w, input int dat_w);
      return hdr_bits(adr_w) + dat_w;
   endfunction

endpackage

// File: rtl/spi_wb_sync.sv
module spi_wb_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 3,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_wb_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[g-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_wb_rx.sv
module spi_wb_rx
   import spi_wb_pkg::*;
#(
   parameter int ADR_W = 23,
   parameter int DAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_act,
   input  logic              sck_rise,
   input  logic              mosi,
   output logic              frame_done,
   output logic              cmd_we,
   output logic [ADR_W-1:0]  cmd_adr,
   output logic [DAT_W-1:0]  cmd_dat
);

   localparam int FRAME_W = frame_bits(ADR_W, DAT_W);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;
   logic               full;

   assign full = (cnt == CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh         <= '0;
         cnt        <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (!ss_act) begin
            cnt <= '0;
         end else if (sck_rise && !full) begin
            sh         <= {sh[FRAME_W-2:0], mosi};
            cnt        <= cnt + CNT_W'(1);
            frame_done <= (cnt == CNT_W'(FRAME_W - 1));
         end
      end
   end

   assign cmd_we  = sh[FRAME_W-1];
   assign cmd_adr = sh[FRAME_W-2 -: ADR_W];
   assign cmd_dat = sh[DAT_W-1:0];

   // R8
   abort_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> (cnt == '0));

   // R9
   extra_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && ss_act && sck_rise) |=> ($stable(sh) && !frame_done));

endmodule

// File: rtl/spi_wb_tx.sv
module spi_wb_tx #(
   parameter int DAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_act,
   input  logic              sck_rise,
   input  logic              load,
   input  logic [DAT_W-1:0]  load_dat,
   output logic              miso
);

   localparam int RPL_W  = DAT_W + 1;
   localparam int LEFT_W = $clog2(RPL_W + 1);

   logic [RPL_W-1:0]  sh;
   logic [LEFT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
         miso <= 1'b0;
      end else if (!ss_act) begin
         sh   <= '0;
         left <= '0;
         miso <= 1'b0;
      end else begin
         if (sck_rise)
            miso <= (left != '0) ? sh[RPL_W-1] : 1'b0;
         if (load) begin
            sh   <= {1'b1, load_dat};
            left <= LEFT_W'(RPL_W);
         end else if (sck_rise && left != '0) begin
            sh   <= {sh[RPL_W-2:0], 1'b0};
            left <= left - LEFT_W'(1);
         end
      end
   end

   // R10
   idle_reply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_act && sck_rise && left == '0 && !load) |=> !miso);

   // R8
   deselect_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> !miso);

   // R6
   marker_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_act && sck_rise && left == LEFT_W'(RPL_W)) |=> miso);

endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge
   import spi_wb_pkg::*;
#(
   parameter int ADR_W       = 23,
   parameter int DAT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_ss_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              wb_cyc_o,
   output logic              wb_stb_o,
   output logic              wb_we_o,
   output logic [ADR_W-1:0]  wb_adr_o,
   output logic [DAT_W-1:0]  wb_dat_o,
   input  logic [DAT_W-1:0]  wb_dat_i,
   input  logic              wb_ack_i
);

   if ((hdr_bits(ADR_W) % 8) != 0) begin : g_bad_adr
      $error("spi_wb_bridge: ADR_W+1 must fill whole bytes");
   end
   if ((DAT_W % 8) != 0 || DAT_W < 8) begin : g_bad_dat
      $error("spi_wb_bridge: DAT_W must be a whole number of bytes");
   end

   // Synchronised pins: {select_n, clock, data-in}, idle values 1,1,0.
   logic [2:0] pins_s;
   logic       ss_act, sck_s, sck_q, sck_rise, mosi_s;

   spi_wb_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (3),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_ss_n, spi_sck, spi_mosi}),
      .q     (pins_s)
   );

   assign ss_act = ~pins_s[2];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b1;
      else        sck_q <= sck_s;
   end
   assign sck_rise = sck_s & ~sck_q;

   logic              rx_done, rx_we;
   logic [ADR_W-1:0]  rx_adr;
   logic [DAT_W-1:0]  rx_dat;

   spi_wb_rx #(
      .ADR_W (ADR_W),
      .DAT_W (DAT_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .ss_act     (ss_act),
      .sck_rise   (sck_rise),
      .mosi       (mosi_s),
      .frame_done (rx_done),
      .cmd_we     (rx_we),
      .cmd_adr    (rx_adr),
      .cmd_dat    (rx_dat)
   );

   bus_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BUS_IDLE;
         wb_we_o  <= 1'b0;
         wb_adr_o <= '0;
         wb_dat_o <= '0;
      end else begin
         case (state)
            BUS_IDLE: if (rx_done) begin
               state    <= BUS_WAIT;
               wb_we_o  <= rx_we;
               wb_adr_o <= rx_adr;
               wb_dat_o <= rx_dat;
            end
            BUS_WAIT: if (wb_ack_i) state <= BUS_IDLE;
            default:  state <= BUS_IDLE;
         endcase
      end
   end

   assign wb_cyc_o = (state == BUS_WAIT);
   assign wb_stb_o = (state == BUS_WAIT);

   logic             tx_load;
   logic [DAT_W-1:0] tx_dat;

   assign tx_load = wb_cyc_o && wb_ack_i && ss_act;
   assign tx_dat  = wb_we_o ? '0 : wb_dat_i;

   spi_wb_tx #(
      .DAT_W (DAT_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ss_act   (ss_act),
      .sck_rise (sck_rise),
      .load     (tx_load),
      .load_dat (tx_dat),
      .miso     (spi_miso)
   );

   // R5
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o)));

   // R5
   drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

   // R5
   start_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_cyc_o) |-> $past(rx_done));

endmodule

// File: tb/tb_spi_wb_bridge.sv
module tb_spi_wb_bridge;

   localparam int NREP = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_ss_n = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0;
   logic        spi_miso;
   logic        wb_cyc_o, wb_stb_o, wb_we_o;
   logic [22:0] wb_adr_o;
   logic [7:0]  wb_dat_o;
   logic [7:0]  wb_dat_i = 8'h00;
   logic        wb_ack_i = 1'b0;

   always #10 clk = ~clk;

   spi_wb_bridge dut (
      .clk(clk), .rst_n(rst_n),
      .spi_ss_n(spi_ss_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
      .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
   );

   int nchk = 0, nfail = 0;
   int cyc_cnt = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   // Bus slave model and per-clock comparison.
   logic [7:0] mem [0:255];
   bit         armed = 1'b0;
   bit         exp_we;
   logic [22:0] exp_adr;
   logic [7:0]  exp_dat;
   int         lat = 0, wait_cnt = 0, ack_cycle = 0, nstarts = 0;
   bit         prev_cyc = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wb_cyc_o && !prev_cyc) nstarts++;
         prev_cyc = wb_cyc_o;
         if (wb_ack_i) begin
            chk(!wb_cyc_o, "R5 cycle drops after ack", {31'd0, wb_cyc_o}, 32'd0);
            wb_ack_i = 1'b0;
         end else if (wb_cyc_o) begin
            chk(armed, "R5 bus cycle without complete frame", 32'd0, 32'd1);
            chk(wb_stb_o, "R5 strobe with cycle", {31'd0, wb_stb_o}, 32'd1);
            chk(wb_we_o == exp_we, "R2 direction", {31'd0, wb_we_o}, {31'd0, exp_we});
            chk(wb_adr_o == exp_adr, "R3 address", {9'd0, wb_adr_o}, {9'd0, exp_adr});
            if (exp_we)
               chk(wb_dat_o == exp_dat, "R4 write data", {24'd0, wb_dat_o}, {24'd0, exp_dat});
            if (wait_cnt >= lat) begin
               if (wb_we_o) mem[wb_adr_o[7:0]] = wb_dat_o;
               wb_dat_i  = wb_we_o ? 8'hEE : mem[wb_adr_o[7:0]];
               wb_ack_i  = 1'b1;
               ack_cycle = cyc_cnt;
               armed     = 1'b0;
               wait_cnt  = 0;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      spi_sck = 1'b0; spi_mosi = b; tick(2);
      spi_sck = 1'b1; tick(2);
   endtask

   task automatic frame(input bit we, input logic [22:0] adr, input logic [7:0] dat,
                        input int latency, input logic fill, input logic [7:0] expect_res);
      logic [31:0] bits;
      bit   smp [NREP];
      int   smp_cyc [NREP];
      int   starts0, m;
      logic [7:0] got;
      bits = {we, adr, dat};
      exp_we = we; exp_adr = adr; exp_dat = dat; lat = latency;
      starts0 = nstarts;
      spi_ss_n = 1'b0; tick(3);
      for (int i = 31; i >= 0; i--) begin
         spi_sck = 1'b0; spi_mosi = bits[i]; tick(2);
         spi_sck = 1'b1;
         if (i == 0) armed = 1'b1;
         tick(2);
      end
      for (int k = 0; k < NREP; k++) begin
         spi_sck = 1'b0; spi_mosi = fill; tick(2);
         smp[k] = spi_miso; smp_cyc[k] = cyc_cnt;
         spi_sck = 1'b1; tick(2);
      end
      spi_ss_n = 1'b1; spi_mosi = 1'b0; tick(6);
      chk(nstarts - starts0 == 1, "R5 R9 one bus cycle per frame", nstarts - starts0, 1);
      m = -1;
      for (int k = NREP - 1; k >= 0; k--) if (smp[k]) m = k;
      chk(m >= 0 && m + 8 < NREP, "R6 marker found", m, 0);
      if (m >= 0 && m + 8 < NREP) begin
         chk(smp_cyc[m] > ack_cycle, "R6 marker after ack", smp_cyc[m], ack_cycle + 1);
         got = '0;
         for (int k = 1; k <= 8; k++) got = {got[6:0], smp[m+k]};
         chk(got == expect_res, we ? "R7 write reply" : "R6 read reply", got, expect_res);
         for (int k = m + 9; k < NREP; k++)
            chk(!smp[k], "R10 trailing zero", smp[k], 0);
      end
      chk(!spi_miso, "R8 idle after deselect", spi_miso, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      tick(4);
      rst_n = 1'b1;
      tick(3);
      // R1
      chk(!wb_cyc_o && !wb_stb_o, "R1 bus idle after reset", {30'd0, wb_cyc_o, wb_stb_o}, 0);
      chk(!spi_miso, "R1 miso low after reset", spi_miso, 0);

      // R2 R4 R7 writes with varied latency
      frame(1'b1, 23'h000010, 8'hA5, 0, 1'b0, 8'h00);
      frame(1'b1, 23'h7FFF11, 8'h3C, 3, 1'b1, 8'h00);
      frame(1'b1, 23'h2A5512, 8'hFF, 17, 1'b0, 8'h00);
      // R3 R6 reads back; R4 data byte on reads ignored
      frame(1'b0, 23'h000010, 8'h77, 0, 1'b0, 8'hA5);
      frame(1'b0, 23'h7FFF11, 8'h00, 25, 1'b1, 8'h3C);
      frame(1'b0, 23'h2A5512, 8'h99, 40, 1'b0, 8'hFF);
      frame(1'b0, 23'h000010, 8'h01, 1, 1'b1, 8'hA5);
      // R3 address extremes
      frame(1'b0, 23'h7FFFFF, 8'h00, 5, 1'b0, mem[8'hFF]);
      frame(1'b0, 23'h000000, 8'hFF, 2, 1'b1, mem[8'h00]);
      frame(1'b0, 23'h5A5A5A, 8'h00, 9, 1'b0, mem[8'h5A]);

      // R8 aborted frame: 13 bits, then deselect
      begin
         int s0;
         s0 = nstarts;
         spi_ss_n = 1'b0; tick(3);
         for (int i = 0; i < 13; i++) shift_bit(i[0]);
         spi_ss_n = 1'b1; tick(30);
         chk(nstarts == s0, "R8 no cycle after abort", nstarts - s0, 0);
         chk(!spi_miso, "R8 miso low after abort", spi_miso, 0);
      end
      // R8 next frame decodes from bit 0
      frame(1'b0, 23'h000012, 8'h00, 4, 1'b0, 8'hFF);
      // R9 ones on data-in during reply after a write
      frame(1'b1, 23'h000033, 8'h81, 12, 1'b1, 8'h00);
      frame(1'b0, 23'h000033, 8'h00, 0, 1'b1, 8'h81);

      finish_run();
   end

endmodule